// File: doc/BRIEF.md
# Interrupt Mask and DMA Request Router

This block holds the pending service requests of a card-interface peripheral and reduces them to one level-sensitive interrupt line for the CPU. There are thirteen request bits. Each has its own set pulse and clear pulse from the peripheral datapath. A thirteen-bit mask register sits beside them and is written over a simple register bus. The interrupt line is high while any request bit is pending and not masked.

A DMA-mode input changes how the two FIFO service requests are handled. When it is set, the receive-service bit (5) and the transmit-service bit (6) are always treated as masked for the CPU interrupt. They drive two dedicated DMA request lines instead. When it is clear, both DMA lines stay low and bits 5 and 6 take part in the interrupt like any other bit.

The request store also takes clock-run and clock-halt commands. These clear and set the clock-off request, bit 4. All three outputs are registered.

Top module: `irq_dma_router`

## Requirements
- R1: `irq_o` is high exactly when the stored request bits AND NOT the effective mask have at least one bit set. The effective mask is the mask register, plus bits 5 and 6 when DMA mode is on.
- R2: A mask write stores only `mask_wdata[12:0]`. `mask_rdata` returns the stored mask in bits 12:0 and zeros in bits 31:13.
- R3: When DMA mode is on, request bits 5 (receive service) and 6 (transmit service) never raise `irq_o`, whatever the mask register holds.
- R4: When DMA mode is on, `dma_rx_req` follows request bit 5 and `dma_tx_req` follows request bit 6.
- R5: When DMA mode is off, `dma_rx_req` and `dma_tx_req` are low.
- R6: A `clk_halt_req` pulse sets request bit 4 (clock off) and a `clk_run_req` pulse clears it. If both arrive in the same cycle, the bit is set.
- R7: A request bit set by its pulse stays set until a clear pulse. If a set pulse and a clear pulse reach the same bit in the same cycle, the bit ends set.
- R8: Inputs are captured into the request, mask and mode state at one clock edge. The outputs reflect the new state at the following edge.
- R9: After reset, all request bits, the mask, the DMA mode and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 13 | One-cycle set pulses, one per request bit |
| src_clr | input | 13 | One-cycle clear pulses, one per request bit |
| clk_run_req | input | 1 | Clock-run command; clears request bit 4 |
| clk_halt_req | input | 1 | Clock-halt command; sets request bit 4 |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wdata | input | 32 | Mask write data; bits 12:0 are kept |
| dma_mode | input | 1 | DMA mode enable |
| mask_rdata | output | 32 | Stored mask, zero-extended |
| irq_o | output | 1 | Level interrupt to the CPU |
| dma_rx_req | output | 1 | Receive-side DMA request |
| dma_tx_req | output | 1 | Transmit-side DMA request |

## Verification
The bench sets the FIFO bits with the mask register clear and DMA mode on, and expects no interrupt. A router that forgot to force those bits masked would raise `irq_o` there. It also sets bit 5 with DMA mode off, where a router that ignored the mode would leak a DMA request. A set and a clear on the same bit in the same cycle must leave the bit pending, and so must simultaneous clock-run and clock-halt commands on bit 4; reversed priority shows up as a silent interrupt line. The bench samples one cycle early to catch outputs that are combinational or two registers late. It also writes all ones to the mask to catch a mask register that keeps bits above 12.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int unsigned SRC_COUNT   = 13;
   localparam int unsigned BUS_WIDTH   = 32;
   // request bit positions decoded by the peripheral and by this router
   localparam int unsigned BIT_XFER_DONE = 0;
   localparam int unsigned BIT_PROG_DONE = 1;
   localparam int unsigned BIT_CMD_END   = 2;
   localparam int unsigned BIT_STOP_END  = 3;
   localparam int unsigned BIT_CLK_OFF   = 4;
   localparam int unsigned BIT_RX_SVC    = 5;
   localparam int unsigned BIT_TX_SVC    = 6;
   localparam int unsigned BIT_TIMEOUT   = 7;
   localparam int unsigned BIT_DATA_ERR  = 8;
   localparam int unsigned BIT_RESP_ERR  = 9;
   localparam int unsigned BIT_RD_STALL  = 10;
   localparam int unsigned BIT_CARD_INT  = 11;
   localparam int unsigned BIT_CARD_ACK  = 12;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
   parameter int unsigned NUM_SRC  = irq_router_pkg::SRC_COUNT,
   parameter int unsigned CLK_BIT  = irq_router_pkg::BIT_CLK_OFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   input  logic               clk_run_i,
   input  logic               clk_halt_i,
   output logic [NUM_SRC-1:0] req_q
);
   if (CLK_BIT >= NUM_SRC) begin : g_bad_clk_bit
      $error("irq_req_bank: CLK_BIT outside request vector");
   end

   for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
      logic set_eff;
      logic clr_eff;
      if (b == CLK_BIT) begin : g_clk
         // halt command raises clock-off, run command drops it
         assign set_eff = set_i[b] | clk_halt_i;
         assign clr_eff = clr_i[b] | clk_run_i;
      end else begin : g_plain
         assign set_eff = set_i[b];
         assign clr_eff = clr_i[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       req_q[b] <= 1'b0;
         else if (set_eff) req_q[b] <= 1'b1;   // set has priority
         else if (clr_eff) req_q[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned NUM_SRC = irq_router_pkg::SRC_COUNT,
   parameter int unsigned DATA_W  = irq_router_pkg::BUS_WIDTH
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic               dma_mode_i,
   output logic [NUM_SRC-1:0] mask_q,
   output logic               dma_mode_q,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (DATA_W <= NUM_SRC) begin : g_bad_width
      $error("irq_mask_reg: bus must be wider than the mask");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '0;
         dma_mode_q <= 1'b0;
      end else begin
         if (wr_en_i) mask_q <= wdata_i[NUM_SRC-1:0];
         dma_mode_q <= dma_mode_i;
      end
   end

   assign rdata_o = {{PAD_W{1'b0}}, mask_q};
endmodule

// File: rtl/irq_route_out.sv
module irq_route_out #(
   parameter int unsigned NUM_SRC = irq_router_pkg::SRC_COUNT,
   parameter int unsigned RX_BIT  = irq_router_pkg::BIT_RX_SVC,
   parameter int unsigned TX_BIT  = irq_router_pkg::BIT_TX_SVC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               dma_mode_i,
   output logic               irq_q,
   output logic               rx_q,
   output logic               tx_q
);
   localparam logic [NUM_SRC-1:0] FIFO_BITS =
      (NUM_SRC'(1) << RX_BIT) | (NUM_SRC'(1) << TX_BIT);

   if (RX_BIT >= NUM_SRC || TX_BIT >= NUM_SRC || RX_BIT == TX_BIT) begin : g_bad_fifo
      $error("irq_route_out: FIFO request bits invalid");
   end

   logic [NUM_SRC-1:0] eff_mask;
   logic [NUM_SRC-1:0] live;

   always_comb begin
      eff_mask = mask_i | (dma_mode_i ? FIFO_BITS : '0);
      live     = req_i & ~eff_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rx_q  <= 1'b0;
         tx_q  <= 1'b0;
      end else begin
         irq_q <= |live;
         rx_q  <= dma_mode_i & req_i[RX_BIT];
         tx_q  <= dma_mode_i & req_i[TX_BIT];
      end
   end
endmodule

// File: rtl/irq_dma_router.sv
module irq_dma_router #(
   parameter int unsigned NUM_SRC = irq_router_pkg::SRC_COUNT,
   parameter int unsigned DATA_W  = irq_router_pkg::BUS_WIDTH,
   parameter int unsigned CLK_BIT = irq_router_pkg::BIT_CLK_OFF,
   parameter int unsigned RX_BIT  = irq_router_pkg::BIT_RX_SVC,
   parameter int unsigned TX_BIT  = irq_router_pkg::BIT_TX_SVC
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_set,
   input  logic [NUM_SRC-1:0] src_clr,
   input  logic               clk_run_req,
   input  logic               clk_halt_req,
   input  logic               mask_wr_en,
   input  logic [DATA_W-1:0]  mask_wdata,
   input  logic               dma_mode,
   output logic [DATA_W-1:0]  mask_rdata,
   output logic               irq_o,
   output logic               dma_rx_req,
   output logic               dma_tx_req
);
   logic [NUM_SRC-1:0] req_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               dma_mode_q;

   irq_req_bank #(.NUM_SRC(NUM_SRC), .CLK_BIT(CLK_BIT)) u_req (
      .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(src_clr),
      .clk_run_i(clk_run_req), .clk_halt_i(clk_halt_req), .req_q(req_q)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .wr_en_i(mask_wr_en), .wdata_i(mask_wdata),
      .dma_mode_i(dma_mode), .mask_q(mask_q), .dma_mode_q(dma_mode_q),
      .rdata_o(mask_rdata)
   );

   irq_route_out #(.NUM_SRC(NUM_SRC), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_out (
      .clk(clk), .rst_n(rst_n), .req_i(req_q), .mask_i(mask_q),
      .dma_mode_i(dma_mode_q), .irq_q(irq_o), .rx_q(dma_rx_req), .tx_q(dma_tx_req)
   );
endmodule

// File: rtl/irq_dma_router_chk.sv
module irq_dma_router_chk #(
   parameter int unsigned NUM_SRC = 13,
   parameter int unsigned CLK_BIT = 4,
   parameter int unsigned RX_BIT  = 5,
   parameter int unsigned TX_BIT  = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_set,
   input logic               clk_halt_req,
   input logic [NUM_SRC-1:0] req_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic               dma_mode_q,
   input logic               irq_o,
   input logic               dma_rx_req,
   input logic               dma_tx_req
);
   localparam logic [NUM_SRC-1:0] FIFO_BITS =
      (NUM_SRC'(1) << RX_BIT) | (NUM_SRC'(1) << TX_BIT);

   // R1
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|(req_q & ~mask_q)));
   // R3
   fifo_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dma_mode_q) && irq_o) |-> $past(|(req_q & ~mask_q & ~FIFO_BITS)));
   // R4
   rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dma_mode_q) |-> (dma_rx_req == $past(req_q[RX_BIT])));
   // R4
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(dma_mode_q) |-> (dma_tx_req == $past(req_q[TX_BIT])));
   // R5
   dma_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(dma_mode_q) |-> (!dma_rx_req && !dma_tx_req));
   // R6
   halt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_halt_req |=> req_q[CLK_BIT]);
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_set) |=> ((req_q & $past(src_set)) == $past(src_set)));
endmodule

bind irq_dma_router irq_dma_router_chk #(
   .NUM_SRC(NUM_SRC), .CLK_BIT(CLK_BIT), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .src_set(src_set), .clk_halt_req(clk_halt_req),
   .req_q(req_q), .mask_q(mask_q), .dma_mode_q(dma_mode_q),
   .irq_o(irq_o), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
);

// File: tb/irq_dma_router_tb.sv
`timescale 1ns/1ps
module irq_dma_router_tb;
   localparam int W = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  src_set = '0;
   logic [W-1:0]  src_clr = '0;
   logic          clk_run_req = 1'b0;
   logic          clk_halt_req = 1'b0;
   logic          mask_wr_en = 1'b0;
   logic [31:0]   mask_wdata = '0;
   logic          dma_mode = 1'b0;
   logic [31:0]   mask_rdata;
   logic          irq_o, dma_rx_req, dma_tx_req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irq_dma_router u_dut (
      .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
      .clk_run_req(clk_run_req), .clk_halt_req(clk_halt_req),
      .mask_wr_en(mask_wr_en), .mask_wdata(mask_wdata), .dma_mode(dma_mode),
      .mask_rdata(mask_rdata), .irq_o(irq_o),
      .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
   );

   typedef struct packed {
      logic [W-1:0] set;
      logic [W-1:0] mask;
      logic         dma;
      logic         irq;
      logic         rx;
      logic         tx;
   } vec_t;

   // bit 5 = receive service, bit 6 = transmit service
   localparam vec_t VECS [9] = '{
      '{13'h0001, 13'h0000, 1'b0, 1'b1, 1'b0, 1'b0},
      '{13'h0001, 13'h0001, 1'b0, 1'b0, 1'b0, 1'b0},
      '{13'h0020, 13'h0000, 1'b1, 1'b0, 1'b1, 1'b0},
      '{13'h0040, 13'h0000, 1'b1, 1'b0, 1'b0, 1'b1},
      '{13'h0060, 13'h0000, 1'b0, 1'b1, 1'b0, 1'b0},
      '{13'h1000, 13'h0FFF, 1'b1, 1'b1, 1'b0, 1'b0},
      '{13'h0060, 13'h1F9F, 1'b1, 1'b0, 1'b1, 1'b1},
      '{13'h0020, 13'h1FFF, 1'b0, 1'b0, 1'b0, 1'b0},
      '{13'h0000, 13'h0000, 1'b1, 1'b0, 1'b0, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // drive one cycle of pulses; returns at the negedge after the capture edge
   task automatic pulse(input logic [W-1:0] s, input logic [W-1:0] c,
                        input logic run, input logic halt,
                        input logic wr, input logic [31:0] wd);
      @(negedge clk);
      src_set = s; src_clr = c; clk_run_req = run; clk_halt_req = halt;
      mask_wr_en = wr; mask_wdata = wd;
      @(negedge clk);
      src_set = '0; src_clr = '0; clk_run_req = 1'b0; clk_halt_req = 1'b0;
      mask_wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      check("R9 irq at reset", {31'd0, irq_o}, 32'd0);
      check("R9 rx at reset", {31'd0, dma_rx_req}, 32'd0);
      check("R9 tx at reset", {31'd0, dma_tx_req}, 32'd0);
      check("R9 mask at reset", mask_rdata, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 irq after release", {31'd0, irq_o}, 32'd0);

      // vector walk: R1 R3 R4 R5
      foreach (VECS[i]) begin
         dma_mode = VECS[i].dma;
         pulse('0, '1, 1'b0, 1'b0, 1'b1, {19'd0, VECS[i].mask});
         pulse(VECS[i].set, '0, 1'b0, 1'b0, 1'b0, 32'd0);
         @(negedge clk);
         check($sformatf("R1/R3 irq vec %0d", i), {31'd0, irq_o}, {31'd0, VECS[i].irq});
         check($sformatf("R4/R5 rx vec %0d", i), {31'd0, dma_rx_req}, {31'd0, VECS[i].rx});
         check($sformatf("R4/R5 tx vec %0d", i), {31'd0, dma_tx_req}, {31'd0, VECS[i].tx});
      end

      // R2 upper write bits dropped
      dma_mode = 1'b0;
      pulse('0, '1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      check("R2 mask readback", mask_rdata, 32'h0000_1FFF);
      pulse('0, '0, 1'b0, 1'b0, 1'b1, 32'hABCD_0000);
      check("R2 mask cleared by low half", mask_rdata, 32'h0000_0000);

      // R8 latency: one edge after capture still old, next edge new
      pulse(13'h0100, '0, 1'b0, 1'b0, 1'b0, 32'd0);
      check("R8 irq not yet", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      check("R8 irq one cycle later", {31'd0, irq_o}, 32'd1);
      // R7 bit persists
      repeat (4) @(negedge clk);
      check("R7 bit holds", {31'd0, irq_o}, 32'd1);
      pulse('0, 13'h0100, 1'b0, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      check("R7 clear drops irq", {31'd0, irq_o}, 32'd0);
      // R7 set beats clear
      pulse(13'h0008, 13'h0008, 1'b0, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      check("R7 set wins over clear", {31'd0, irq_o}, 32'd1);
      pulse('0, '1, 1'b0, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      check("R7 cleared", {31'd0, irq_o}, 32'd0);

      // R6 clock-off bit 4
      pulse('0, '0, 1'b0, 1'b1, 1'b0, 32'd0);
      @(negedge clk);
      check("R6 halt sets clock-off", {31'd0, irq_o}, 32'd1);
      pulse('0, '0, 1'b1, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      check("R6 run clears clock-off", {31'd0, irq_o}, 32'd0);
      pulse('0, '0, 1'b1, 1'b1, 1'b0, 32'd0);
      @(negedge clk);
      check("R6 halt wins over run", {31'd0, irq_o}, 32'd1);
      pulse('0, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0010);
      @(negedge clk);
      check("R6 clock-off maskable", {31'd0, irq_o}, 32'd0);

      // R5 toggling mode off drops DMA request with bit 5 pending
      pulse('0, '1, 1'b0, 1'b0, 1'b1, 32'd0);
      dma_mode = 1'b1;
      pulse(13'h0020, '0, 1'b0, 1'b0, 1'b0, 32'd0);
      @(negedge clk);
      check("R4 rx high in dma mode", {31'd0, dma_rx_req}, 32'd1);
      dma_mode = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R5 rx low after mode off", {31'd0, dma_rx_req}, 32'd0);
      check("R3 bit 5 reaches irq when mode off", {31'd0, irq_o}, 32'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #20000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule